// File: doc/BRIEF.md
# Key-Locked Vector Base Register Bank

This block holds the base address of the interrupt vector table in two 16-bit registers, a low half and a high half, and presents the combined 32-bit value to the processor core. Both halves are guarded by a lock. Writes to them take effect only while the bank is unlocked. A separate 16-bit key register controls the lock. Writing the value 0x0096 to it opens the bank, and writing any other value closes it again.

Software reaches the bank over a simple synchronous register bus with a word address, write data, a write strobe and combinational read data. The normal sequence is to write the key, update the base halves, then write any other value to the key so that later stray writes cannot move the vector table. After reset the bank is locked and the base equals a default set by a parameter. The low half always keeps its bits [7:0] at zero, so the table stays aligned to 256 bytes.

Top module: `vbase_bank`

## Requirements
- R1: After reset the bank is locked, key-register reads return 0x0001, and `vec_base` equals the parameter `DEFAULT_BASE` with bits [7:0] forced to zero.
- R2: A write of exactly 0x0096 to the key register (address 0) unlocks the bank from the next cycle, and key-register reads then return 0x0000.
- R3: A write of any value other than 0x0096 to the key register locks the bank from the next cycle, and key-register reads then return 0x0001.
- R4: While locked, writes to the low half (address 1) or the high half (address 2) are ignored, and both `vec_base` and the read data stay unchanged.
- R5: While unlocked, a write to address 1 sets `vec_base[15:8]` to wdata[15:8] in the next cycle, and a write to address 2 sets `vec_base[31:16]` to wdata in the next cycle.
- R6: Bits [7:0] of the low half always read as zero, and writes to them are discarded.
- R7: Writes to the key register are accepted whether the bank is locked or unlocked. Reads of address 3 return zero, and writes to address 3 change no state.
- R8: `rdata` is combinational: address 1 returns `vec_base[15:0]` and address 2 returns `vec_base[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word address (0 key, 1 base low, 2 base high) |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| vec_base | output | 32 | Vector table base address {high, low} |

## Verification
A wrong lock state shows at the ports in the cycle after the faulty key write, because the key read value flips at once. The error also shows on the first later base write, because `vec_base` either moves when it should stay or stays when it should move. A damaged base register shows directly on `vec_base` one cycle after the write, and a broken alignment mask shows as nonzero low bits on both the read port and the base output. The bench therefore checks after every write, in the following cycle, and never waits several operations before comparing.

// File: rtl/vbase_pkg.sv
package vbase_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned ALIGN_BITS = 8;
    localparam logic [REG_W-1:0] UNLOCK_KEY = 16'h0096;
    localparam logic [REG_W-1:0] RD_LOCKED   = 16'h0001;
    localparam logic [REG_W-1:0] RD_UNLOCKED = 16'h0000;

    typedef enum logic [ADDR_W-1:0] {
        SEL_KEY  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       key;
        logic       low;
        logic       high;
    } wr_strobe_t;

    function automatic logic [REG_W-1:0] align_low(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] m;
        m = v;
        m[ALIGN_BITS-1:0] = '0;
        return m;
    endfunction
endpackage

// File: rtl/vbase_decode.sv
module vbase_decode
    import vbase_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wr_strobe_t        stb
);
    reg_sel_e sel;
    always_comb begin
        sel = reg_sel_e'(addr);
        stb = '0;
        if (we) begin
            unique case (sel)
                SEL_KEY:  stb.key  = 1'b1;
                SEL_LOW:  stb.low  = 1'b1;
                SEL_HIGH: stb.high = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/vbase_lock.sv
module vbase_lock
    import vbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [REG_W-1:0] key_data,
    output logic             locked
);
    always_ff @(posedge clk) begin
        if (rst)         locked <= 1'b1;
        else if (key_we) locked <= (key_data != UNLOCK_KEY);
    end
endmodule

// File: rtl/vbase_half.sv
module vbase_half
    import vbase_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = '0,
    parameter bit               ALIGNED   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] nxt;
    logic [REG_W-1:0] rst_v;
    generate
        if (ALIGNED) begin : g_al
            assign nxt   = align_low(wdata);
            assign rst_v = align_low(RESET_VAL);
        end else begin : g_pl
            assign nxt   = wdata;
            assign rst_v = RESET_VAL;
        end
    endgenerate
    always_ff @(posedge clk) begin
        if (rst)     q <= rst_v;
        else if (wr) q <= nxt;
    end
endmodule

// File: rtl/vbase_bank.sv
module vbase_bank
    import vbase_pkg::*;
#(
    parameter logic [31:0] DEFAULT_BASE = 32'h0000_8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    output logic [15:0] bus_rdata,
    output logic [31:0] vec_base
);
    wr_strobe_t       stb;
    logic             locked;
    logic [REG_W-1:0] lo_q, hi_q;

    vbase_decode u_dec (.addr(bus_addr), .we(bus_we), .stb(stb));

    vbase_lock u_lock (
        .clk(clk), .rst(rst), .key_we(stb.key),
        .key_data(bus_wdata), .locked(locked)
    );

    vbase_half #(.RESET_VAL(DEFAULT_BASE[15:0]), .ALIGNED(1'b1)) u_lo (
        .clk(clk), .rst(rst), .wr(stb.low && !locked),
        .wdata(bus_wdata), .q(lo_q)
    );

    vbase_half #(.RESET_VAL(DEFAULT_BASE[31:16]), .ALIGNED(1'b0)) u_hi (
        .clk(clk), .rst(rst), .wr(stb.high && !locked),
        .wdata(bus_wdata), .q(hi_q)
    );

    assign vec_base = {hi_q, lo_q};

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_KEY:  bus_rdata = locked ? RD_LOCKED : RD_UNLOCKED;
            SEL_LOW:  bus_rdata = lo_q;
            SEL_HIGH: bus_rdata = hi_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vbase_bank_chk.sv
module vbase_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_we,
    input logic [15:0] bus_rdata,
    input logic [31:0] vec_base,
    input logic        locked
);
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (locked && bus_we && bus_addr != 2'd0) |=> $stable(vec_base)) else $error("R4");  // R4
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        vec_base[7:0] == 8'h00) else $error("R6");  // R6
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd0 && bus_wdata == 16'h0096) |=> !locked) else $error("R2");  // R2
    AST_BADKEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd0 && bus_wdata != 16'h0096) |=> locked) else $error("R3");  // R3
    AST_HIGH_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!locked && bus_we && bus_addr == 2'd2) |=> vec_base[31:16] == $past(bus_wdata)) else $error("R5");  // R5
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd3) |=> ($stable(vec_base) && $stable(locked))) else $error("R7");  // R7
endmodule

bind vbase_bank vbase_bank_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .vec_base(vec_base), .locked(locked)
);

// File: tb/vbase_bank_bench.sv
`timescale 1ns/1ps
module vbase_bank_bench;
    localparam logic [31:0] DEF = 32'h1234_56AB;
    logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [31:0] vec_base;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    vbase_bank #(.DEFAULT_BASE(DEF)) u_vbase_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .vec_base(vec_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(2'd0, d); chk("R1", {16'h0, d}, 32'h1);
        chk("R1", vec_base, 32'h1234_5600);
    endtask

    task automatic t_locked_ignored;
        logic [15:0] d;
        wr(2'd1, 16'hBEEF); chk("R4", vec_base, 32'h1234_5600);
        wr(2'd2, 16'hCAFE); chk("R4", vec_base, 32'h1234_5600);
        rd(2'd2, d); chk("R4", {16'h0, d}, 32'h1234);
    endtask

    task automatic t_unlock_write;
        logic [15:0] d;
        wr(2'd0, 16'h0096); rd(2'd0, d); chk("R2", {16'h0, d}, 32'h0);
        wr(2'd1, 16'hA5FF); chk("R5", vec_base, 32'h1234_A500);
        wr(2'd2, 16'h0F0E); chk("R5", vec_base, 32'h0F0E_A500);
        rd(2'd1, d); chk("R6", {16'h0, d}, 32'hA500);
        rd(2'd2, d); chk("R8", {16'h0, d}, 32'h0F0E);
        wr(2'd0, 16'h0096); rd(2'd0, d); chk("R7", {16'h0, d}, 32'h0);
    endtask

    task automatic t_addr3;
        logic [15:0] d;
        wr(2'd3, 16'hFFFF); rd(2'd3, d); chk("R7", {16'h0, d}, 32'h0);
        chk("R7", vec_base, 32'h0F0E_A500);
        rd(2'd0, d); chk("R7", {16'h0, d}, 32'h0);
    endtask

    task automatic t_relock;
        logic [15:0] d;
        wr(2'd0, 16'h0097); rd(2'd0, d); chk("R3", {16'h0, d}, 32'h1);
        wr(2'd2, 16'h7777); chk("R3", vec_base, 32'h0F0E_A500);
        wr(2'd0, 16'h0096); wr(2'd0, 16'h9600); rd(2'd0, d); chk("R3", {16'h0, d}, 32'h1);
        wr(2'd1, 16'h1111); chk("R4", vec_base, 32'h0F0E_A500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked_ignored();
        t_unlock_write();
        t_addr3();
        t_relock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule